// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the bus-facing command front end of a 1M x 16 boot-block NOR flash model. The host drives active-low chip-select, read-strobe and write-strobe lines with no timing relation to the block clock. The block resamples them, takes an 8-bit opcode from the low data byte on each completed write, and keeps track of which source a read returns: the array, the identifier words or the status byte. Some commands take two bus writes. Program and erase are two-write sequences, and each one ends in a single-cycle request to a separate operation sequencer. The same sequencer receives suspend and resume requests. The sequencer reports back its busy flag, its suspend flags and its sticky error events, and the block folds these into the status byte.

While the sequencer is busy, the block accepts one command only: suspend. A status read captures the status byte once, when the read cycle opens, and holds that value until the cycle closes. The active-low power-down input also serves as the reset. While it is low, the data bus is not driven, the read mode goes back to array and all sticky status flags are cleared.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rp_n` is low, `dq_oe` is 0 whatever the strobes do. After `rp_n` rises, reads return array data and the four sticky status flags read as 0.
- R2: Opcode 0xFF selects array reads, 0x90 selects identifier reads and 0x70 selects status reads. The selected mode stays in force for every later read until another command is accepted.
- R3: In identifier mode, word address 0 reads 0x002C. Word address 1 reads 0x4490 when `TOP_BOOT`=1 or 0x4491 when `TOP_BOOT`=0. Every other address reads 0.
- R4: A status read returns 0 on bits 15:8. The low byte is: bit7 = NOT `seq_busy` (ready), bit6 = erase suspended, bit5 = erase error, bit4 = program error, bit3 = supply error, bit2 = program suspended, bit1 = lock error, bit0 = 0. `seq_flag_set` bits 0..3 set the sticky flags for lock, supply, program and erase.
- R5: The status byte is captured when the read cycle opens, meaning the later of the chip-select and read-strobe falling edges. It stays constant for the rest of that read, even if its inputs change.
- R6: Opcode 0x10 or 0x40, followed by a second write, produces one `req_prog` pulse. The pulse carries that second write's address and data word, and reads then return status.
- R7: Opcode 0x20, followed by 0xD0, produces one `req_erase` pulse carrying the address of the 0xD0 write.
- R8: Opcode 0x20 followed by any value other than 0xD0 issues no erase request. It returns the block to array reads and sets the program-error and erase-error flags (status 0xB0 when idle).
- R9: While `seq_busy` is high, every opcode except 0xB0 is ignored. Opcode 0xB0 yields one `req_suspend` pulse and selects status reads.
- R10: When the sequencer is idle and reports a suspend, opcode 0xD0 yields one `req_resume` pulse.
- R11: Opcode 0x50 clears the four sticky flags and returns the block to array reads.
- R12: Opcodes 0x60, 0xAF and other unlisted values leave the read mode unchanged and issue no request.
- R13: A write is taken on the rising edge of the resampled `we_n`, and only while `ce_n` is low. A write-strobe pulse with `ce_n` high has no effect.
- R14: No two request outputs are high in the same cycle, and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rp_n | input | 1 | Active-low power-down and asynchronous reset |
| ce_n | input | 1 | Active-low chip select, asynchronous |
| oe_n | input | 1 | Active-low read strobe, asynchronous |
| we_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | ADDR_W (20) | Word address, held stable around each strobe |
| dq_in | input | DATA_W (16) | Write data; the low byte carries the opcode |
| dq_out | output | DATA_W (16) | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| arr_addr | output | ADDR_W (20) | Array read-port address |
| arr_rdata | input | DATA_W (16) | Array read-port data |
| seq_busy | input | 1 | Sequencer operation in progress |
| seq_susp_erase | input | 1 | Sequencer reports erase suspended |
| seq_susp_prog | input | 1 | Sequencer reports program suspended |
| seq_flag_set | input | 4 | Sticky error set pulses: lock, supply, program, erase |
| req_prog | output | 1 | Program request pulse |
| req_erase | output | 1 | Erase request pulse |
| req_suspend | output | 1 | Suspend request pulse |
| req_resume | output | 1 | Resume request pulse |
| req_addr | output | ADDR_W (20) | Address for program or erase |
| req_data | output | DATA_W (16) | Word to program |

## Verification
The bench exercises the decoder with four kinds of bus activity:
- Single-write mode commands, to separate the three read sources.
- Two-write program and erase sequences, including the erase sequence with a wrong second write, to separate a completed request from an abort.
- Opcodes written while the sequencer is busy, to show that only suspend gets through.
- Strobe patterns with chip select high, or with the status inputs changing in the middle of a read, to show that a write needs chip select and that the status snapshot is frozen per read cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_PROG_ARM  = 2'd1,
        SEQ_ERASE_ARM = 2'd2
    } seq_st_e;

    localparam logic [7:0] OPC_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OPC_IDENT      = 8'h90;
    localparam logic [7:0] OPC_READ_STAT  = 8'h70;
    localparam logic [7:0] OPC_CLR_STAT   = 8'h50;
    localparam logic [7:0] OPC_PROG_A     = 8'h10;
    localparam logic [7:0] OPC_PROG_B     = 8'h40;
    localparam logic [7:0] OPC_ERASE      = 8'h20;
    localparam logic [7:0] OPC_CONFIRM    = 8'hD0;
    localparam logic [7:0] OPC_SUSPEND    = 8'hB0;

    localparam logic [15:0] ID_MAKER   = 16'h002C;
    localparam logic [15:0] ID_DEV_TOP = 16'h4490;
    localparam logic [15:0] ID_DEV_BOT = 16'h4491;

    // sticky flag positions inside the flag vector
    localparam int FLG_LOCK  = 0;
    localparam int FLG_VPP   = 1;
    localparam int FLG_PROG  = 2;
    localparam int FLG_ERASE = 3;
    localparam int FLG_N     = 4;

endpackage

// File: rtl/flash_cmd_sync.sv
module flash_cmd_sync #(
    parameter int N_BITS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] async_i,
    output logic [N_BITS-1:0] sync_o,
    output logic [N_BITS-1:0] prev_o
);
    // STAGES resampling flops plus one history flop per strobe
    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < N_BITS; g++) begin : g_bit
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seq_busy,
    input  logic              seq_suspended,
    output rd_mode_e          mode,
    output logic              req_prog,
    output logic              req_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              clr_stat,
    output logic              erase_abort
);
    typedef struct packed {
        seq_st_e           st;
        rd_mode_e          mode;
        logic              prog;
        logic              erase;
        logic              susp;
        logic              resume;
        logic              clr;
        logic              abort;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t       fsm_d, fsm_q;
    logic [7:0] opc;

    assign opc = wr_data[7:0];

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.prog   = 1'b0;
        fsm_d.erase  = 1'b0;
        fsm_d.susp   = 1'b0;
        fsm_d.resume = 1'b0;
        fsm_d.clr    = 1'b0;
        fsm_d.abort  = 1'b0;
        if (wr_evt) begin
            if (seq_busy) begin
                // only suspend is honoured while an operation runs
                if (opc == OPC_SUSPEND) begin
                    fsm_d.susp = 1'b1;
                    fsm_d.mode = MODE_STATUS;
                end
            end else begin
                case (fsm_q.st)
                    SEQ_PROG_ARM: begin
                        fsm_d.prog = 1'b1;
                        fsm_d.addr = wr_addr;
                        fsm_d.data = wr_data;
                        fsm_d.st   = SEQ_IDLE;
                        fsm_d.mode = MODE_STATUS;
                    end
                    SEQ_ERASE_ARM: begin
                        fsm_d.st = SEQ_IDLE;
                        if (opc == OPC_CONFIRM) begin
                            fsm_d.erase = 1'b1;
                            fsm_d.addr  = wr_addr;
                            fsm_d.mode  = MODE_STATUS;
                        end else begin
                            fsm_d.abort = 1'b1;
                            fsm_d.mode  = MODE_ARRAY;
                        end
                    end
                    default: begin
                        case (opc)
                            OPC_READ_ARRAY: fsm_d.mode = MODE_ARRAY;
                            OPC_IDENT:      fsm_d.mode = MODE_IDENT;
                            OPC_READ_STAT:  fsm_d.mode = MODE_STATUS;
                            OPC_CLR_STAT: begin
                                fsm_d.clr  = 1'b1;
                                fsm_d.mode = MODE_ARRAY;
                            end
                            OPC_PROG_A, OPC_PROG_B: begin
                                fsm_d.st   = SEQ_PROG_ARM;
                                fsm_d.mode = MODE_STATUS;
                            end
                            OPC_ERASE: begin
                                fsm_d.st   = SEQ_ERASE_ARM;
                                fsm_d.mode = MODE_STATUS;
                            end
                            OPC_CONFIRM: begin
                                if (seq_suspended) begin
                                    fsm_d.resume = 1'b1;
                                    fsm_d.mode   = MODE_STATUS;
                                end
                            end
                            default: ; // reserved or unknown: no effect
                        endcase
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q      <= '0;
            fsm_q.st   <= SEQ_IDLE;
            fsm_q.mode <= MODE_ARRAY;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign mode        = fsm_q.mode;
    assign req_prog    = fsm_q.prog;
    assign req_erase   = fsm_q.erase;
    assign req_suspend = fsm_q.susp;
    assign req_resume  = fsm_q.resume;
    assign req_addr    = fsm_q.addr;
    assign req_data    = fsm_q.data;
    assign clr_stat    = fsm_q.clr;
    assign erase_abort = fsm_q.abort;

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_busy,
    input  logic             seq_susp_erase,
    input  logic             seq_susp_prog,
    input  logic [FLG_N-1:0] seq_flag_set,
    input  logic             clr,
    input  logic             abort,
    input  logic             rd_start,
    output logic [7:0]       stat_snap
);
    typedef struct packed {
        logic [FLG_N-1:0] flags;
        logic [7:0]       snap;
    } stat_t;

    stat_t            st_d, st_q;
    logic [7:0]       live;
    logic [FLG_N-1:0] abort_set;

    always_comb begin
        abort_set            = '0;
        abort_set[FLG_PROG]  = abort;
        abort_set[FLG_ERASE] = abort;
        live = {~seq_busy, seq_susp_erase, st_q.flags[FLG_ERASE],
                st_q.flags[FLG_PROG], st_q.flags[FLG_VPP], seq_susp_prog,
                st_q.flags[FLG_LOCK], 1'b0};
        st_d       = st_q;
        st_d.flags = (clr ? '0 : st_q.flags) | seq_flag_set | abort_set;
        if (rd_start) st_d.snap = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_snap = st_q.snap;

endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              rp_n,
    input  logic              rd_act,
    input  rd_mode_e          mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [7:0]        stat_snap,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam logic [15:0] DEV_ID = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (mode)
            MODE_ARRAY: sel = arr_rdata;
            MODE_IDENT: begin
                if (addr == ADDR_W'(0))      sel = DATA_W'(ID_MAKER);
                else if (addr == ADDR_W'(1)) sel = DATA_W'(DEV_ID);
            end
            MODE_STATUS: sel = {{(DATA_W-8){1'b0}}, stat_snap};
            default: sel = '0;
        endcase
    end

    assign dq_oe  = rp_n & rd_act;
    assign dq_out = dq_oe ? sel : '0;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit TOP_BOOT    = 1'b1
) (
    input  logic              clk,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              seq_busy,
    input  logic              seq_susp_erase,
    input  logic              seq_susp_prog,
    input  logic [3:0]        seq_flag_set,
    output logic              req_prog,
    output logic              req_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    // strobe index inside the resampled vector
    localparam int S_CE = 0;
    localparam int S_OE = 1;
    localparam int S_WE = 2;
    localparam int S_N  = 3;

    logic [S_N-1:0] strb_s, strb_p;
    logic           wr_evt, rd_act, rd_act_p, rd_start;
    logic           clr_stat, erase_abort;
    rd_mode_e       mode;
    logic [7:0]     stat_snap;

    flash_cmd_sync #(.N_BITS(S_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rp_n),
        .async_i ({we_n, oe_n, ce_n}),
        .sync_o  (strb_s),
        .prev_o  (strb_p)
    );

    assign wr_evt   = strb_s[S_WE] & ~strb_p[S_WE] & ~strb_s[S_CE];
    assign rd_act   = ~strb_s[S_CE] & ~strb_s[S_OE] & strb_s[S_WE];
    assign rd_act_p = ~strb_p[S_CE] & ~strb_p[S_OE] & strb_p[S_WE];
    assign rd_start = rd_act & ~rd_act_p;
    assign arr_addr = addr;

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rp_n),
        .wr_evt        (wr_evt),
        .wr_addr       (addr),
        .wr_data       (dq_in),
        .seq_busy      (seq_busy),
        .seq_suspended (seq_susp_erase | seq_susp_prog),
        .mode          (mode),
        .req_prog      (req_prog),
        .req_erase     (req_erase),
        .req_suspend   (req_suspend),
        .req_resume    (req_resume),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .clr_stat      (clr_stat),
        .erase_abort   (erase_abort)
    );

    flash_cmd_status u_stat (
        .clk            (clk),
        .rst_n          (rp_n),
        .seq_busy       (seq_busy),
        .seq_susp_erase (seq_susp_erase),
        .seq_susp_prog  (seq_susp_prog),
        .seq_flag_set   (seq_flag_set),
        .clr            (clr_stat),
        .abort          (erase_abort),
        .rd_start       (rd_start),
        .stat_snap      (stat_snap)
    );

    flash_cmd_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) u_rdmux (
        .rp_n      (rp_n),
        .rd_act    (rd_act),
        .mode      (mode),
        .addr      (addr),
        .arr_rdata (arr_rdata),
        .stat_snap (stat_snap),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
    input logic clk,
    input logic rp_n,
    input logic dq_oe,
    input logic seq_busy,
    input logic req_prog,
    input logic req_erase,
    input logic req_suspend,
    input logic req_resume
);
    // R14
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rp_n)
        $onehot0({req_prog, req_erase, req_suspend, req_resume}));

    // R14
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rp_n)
        req_prog |=> !req_prog);

    // R14
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rp_n)
        req_erase |=> !req_erase);

    // R9
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rp_n)
        seq_busy |=> !(req_prog || req_erase || req_resume));

    // R1
    always @(posedge clk) begin
        if (!rp_n) begin
            rp_quiet_chk: assert (!dq_oe);
        end
    end

endmodule

bind flash_cmd_decoder flash_cmd_chk u_chk (
    .clk         (clk),
    .rp_n        (rp_n),
    .dq_oe       (dq_oe),
    .seq_busy    (seq_busy),
    .req_prog    (req_prog),
    .req_erase   (req_erase),
    .req_suspend (req_suspend),
    .req_resume  (req_resume)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rp_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata;
    logic          seq_busy = 1'b0, seq_susp_erase = 1'b0, seq_susp_prog = 1'b0;
    logic [3:0]    seq_flag_set = '0;
    logic          req_prog, req_erase, req_suspend, req_resume;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;

    int n_checks = 0;
    int n_errors = 0;
    int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    bit done = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    event          smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    // array read port model
    assign arr_rdata = arr_addr[15:0] ^ 16'h5A3C;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .TOP_BOOT(1'b1)) u_dut (
        .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .seq_busy(seq_busy), .seq_susp_erase(seq_susp_erase), .seq_susp_prog(seq_susp_prog),
        .seq_flag_set(seq_flag_set),
        .req_prog(req_prog), .req_erase(req_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .req_addr(req_addr), .req_data(req_data)
    );

    always @(posedge clk) begin
        if (req_prog)    begin n_prog++;  last_addr = req_addr; last_data = req_data; end
        if (req_erase)   begin n_erase++; last_addr = req_addr; end
        if (req_suspend) n_susp++;
        if (req_resume)  n_res++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each sampled read against the queued expectation
    initial begin
        forever begin
            @(smp_ev);
            begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dq_oe === 1'b1 && dq_out === e, t, {15'd0, dq_oe, dq_out}, {16'd1, e});
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk); we_n = 1'b1;
        repeat (5) @(negedge clk); ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_sample(input logic [DW-1:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        ->smp_ev;
        #1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        expect_sample(e, t);
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: bus stays undriven in power-down even with strobes active
        repeat (2) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        check(dq_oe === 1'b0, "R1 power-down oe", {31'd0, dq_oe}, 32'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        rp_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(20'h12345, 16'h2345 ^ 16'h5A3C, "R1 array after reset");
        bus_write(0, 16'h0070);
        bus_read(0, 16'h0080, "R4 idle status");

        // R6: program sequence with opcode 0x40
        bus_write(0, 16'h0040);
        bus_write(20'h00321, 16'hBEEF);
        check(n_prog == 1 && last_addr == 20'h00321 && last_data == 16'hBEEF, "R6 prog req",
              {n_prog[3:0], last_addr[11:0], last_data}, {4'd1, 12'h321, 16'hBEEF});

        // R4/R5: busy visible, and snapshot frozen within a read
        seq_busy = 1'b1;
        bus_read(0, 16'h0000, "R4 busy status");
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        expect_sample(16'h0000, "R5 snapshot first");
        seq_busy = 1'b0;
        repeat (5) @(negedge clk);
        expect_sample(16'h0000, "R5 snapshot held");
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(0, 16'h0080, "R5 new read refreshes");

        // R9: busy gates everything except suspend
        seq_busy = 1'b1;
        bus_write(0, 16'h00FF);
        bus_read(20'h00010, 16'h0000, "R9 read-array ignored while busy");
        bus_write(0, 16'h00B0);
        check(n_susp == 1, "R9 suspend req", n_susp, 1);
        seq_busy = 1'b0; seq_susp_prog = 1'b1;
        bus_read(0, 16'h0084, "R4 program suspended bit");

        // R10: resume
        bus_write(0, 16'h00D0);
        check(n_res == 1, "R10 resume req", n_res, 1);
        seq_susp_prog = 1'b0;
        bus_read(0, 16'h0080, "R10 status after resume");

        // R4/R11: sticky flag then clear
        @(negedge clk); seq_flag_set = 4'b0010;
        @(negedge clk); seq_flag_set = 4'b0000;
        bus_read(0, 16'h0088, "R4 supply flag");
        bus_write(0, 16'h0050);
        bus_read(20'h00ABC, 16'h0ABC ^ 16'h5A3C, "R11 array after clear");
        bus_write(0, 16'h0070);
        bus_read(0, 16'h0080, "R11 flags cleared");

        // R7: erase
        bus_write(20'h45000, 16'h0020);
        bus_write(20'h45678, 16'h00D0);
        check(n_erase == 1 && last_addr == 20'h45678, "R7 erase req",
              {n_erase[11:0], last_addr}, {12'd1, 20'h45678});

        // R8: erase abort
        bus_write(0, 16'h0020);
        bus_write(0, 16'h00FF);
        bus_read(20'h00010, 16'h0010 ^ 16'h5A3C, "R8 array after abort");
        check(n_erase == 1, "R8 no erase req", n_erase, 1);
        bus_write(0, 16'h0070);
        bus_read(0, 16'h00B0, "R8 abort flags");

        // R12: reserved codes keep status mode
        bus_write(0, 16'h0060);
        bus_read(0, 16'h00B0, "R12 code 60 ignored");
        bus_write(0, 16'h00AF);
        bus_read(0, 16'h00B0, "R12 code AF ignored");

        // R2/R3: identifier mode held across reads
        bus_write(0, 16'h0090);
        bus_read(20'h00000, 16'h002C, "R3 maker id");
        bus_read(20'h00001, 16'h4490, "R3 device id");
        bus_read(20'h00002, 16'h0000, "R3 other addr");
        bus_read(20'h00000, 16'h002C, "R2 mode held");

        // R13: write strobe with chip select high has no effect
        @(negedge clk); addr = 0; dq_in = 16'h00FF;
        repeat (3) @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk); we_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_read(20'h00000, 16'h002C, "R13 deselected write ignored");

        // R6: alternate program opcode
        bus_write(0, 16'h0010);
        bus_write(20'h00007, 16'h1234);
        check(n_prog == 2 && last_data == 16'h1234, "R6 alt prog req",
              {n_prog[15:0], last_data}, {16'd2, 16'h1234});

        // R1: reset mid-session clears flags and mode
        bus_write(0, 16'h0020);
        bus_write(0, 16'h0000);
        bus_write(0, 16'h0090);
        @(negedge clk); rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check(dq_oe === 1'b0, "R1 power-down mid session", {31'd0, dq_oe}, 32'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); rp_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(20'h00055, 16'h0055 ^ 16'h5A3C, "R1 array mode after reset");
        bus_write(0, 16'h0070);
        bus_read(0, 16'h0080, "R1 flags cleared by reset");

        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule